// File: doc/BRIEF.md
# Constant-Multiplier Bit-Matrix Engine over GF(2^w)

This block multiplies a stream of w-bit field elements by one fixed constant in GF(2^w). When a constant and a reduction polynomial are loaded, a small sequencer spends one cycle per bit of the constant building the w×w bit-dependency matrix of the map x → x·n. Row i of that matrix lists which input bits feed output bit i.

After the matrix is built, each incoming word passes through AND gates and parity trees only: output bit i is the XOR of the bits of (word AND row i). For a 16-bit field, the matrix is cut into four 8×8 byte blocks. The low product byte is the byte-affine of the low input byte by the block holding the low halves of rows 0–7, XOR the byte-affine of the high input byte by the block holding the high halves of those rows. The high product byte is formed the same way from rows 8–15.

Words enter and leave on valid/ready streams through a single output register. A new constant requested while words are still in flight is held back. It is applied only after the output register has emptied.

Top module: `gf_matmul_engine`

## Requirements
- R1: After reset, busy_o is 0, in_ready_o is 1 and out_valid_o is 0. The matrix is all-zero, so any word accepted before the first load produces 0.
- R2: A load pulse (load_i high while busy_o is 0) raises busy_o from the next cycle. When no word is in flight, busy_o stays high for exactly W+1 cycles: one to start, and W for matrix generation, one per constant bit from bit W-1 down to bit 0. in_ready_o is 0 whenever busy_o is 1.
- R3: The polynomial port carries the reduction polynomial without its x^W term. With W=16, poly_i=0x002B and n=2, output bit 0 equals input bit 15. Output bits 1, 3 and 5 equal input bit (i-1) XOR input bit 15, and every other output bit equals input bit (i-1). For example, 0x8001 gives 0x0029 and 0x4000 gives 0x8000.
- R4: For any loaded constant n and polynomial, every output word equals the field product x·n modulo (x^W + poly_i). This holds for words whose high and low bytes both contribute to both product bytes.
- R5: A word accepted on a rising edge appears on out_data_o, with out_valid_o high, right after that same edge (one-cycle latency). If out_ready_i is 1 and no new word is accepted, out_valid_o falls after the next edge.
- R6: While out_valid_o is 1 and out_ready_i is 0, out_data_o holds its value and in_ready_o is 0. Once out_ready_i returns to 1, a waiting word is accepted in the same cycle that the held word leaves.
- R7: A load made while a word sits in the output register does not disturb that word, which keeps the product of the old constant. Matrix generation starts only after the register has emptied, and words accepted afterwards use the new constant.
- R8: A load pulse while busy_o is 1 is ignored: later products use the constant from the accepted load.
- R9: Constant 1 gives the identity (output equals input), and constant 0 gives an all-zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Request to load a new constant and polynomial |
| const_i | input | W | Field constant n |
| poly_i | input | W | Reduction polynomial, x^W term omitted |
| busy_o | output | 1 | Load pending or matrix generation running |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | W | Input field element |
| in_ready_o | output | 1 | Engine can take an input word |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | W | Product of input word and constant |
| out_ready_i | input | 1 | Downstream takes the output word |

## Verification
A constant load and the streaming of words can fall in the same cycle. The bench provokes this by holding a product in the output register with out_ready_i low, then pulsing load_i while another word waits on the input. It judges the outcome by checking three things: the held word keeps the product of the old constant, busy_o stays high and no word is accepted until the register drains, and the waiting word, once taken, carries the product of the new constant. A load arriving during generation is judged by which constant the following products reflect.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    typedef logic [7:0]      gfm_byte_t;
    typedef gfm_byte_t [7:0] gfm_mat8_t;

    // Byte-wide affine map: result bit i is the parity of (x AND row i).
    function automatic gfm_byte_t gfm_affine8(input gfm_byte_t x, input gfm_mat8_t m);
        gfm_byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[i] = ^(x & m[i]);
        end
        return r;
    endfunction

endpackage

// File: rtl/gfm_matrix_gen.sv
module gfm_matrix_gen #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [W-1:0]        n_i,
    input  logic [W-1:0]        poly_i,
    output logic                active_o,
    output logic [W-1:0][W-1:0] rows_o
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic                active;
        logic [BW-1:0]       bit_idx;
        logic [W-1:0]        n;
        logic [W-1:0]        poly;
        logic [W-1:0][W-1:0] rows;
    } gen_state_t;

    gen_state_t st_q, st_d;
    logic [W-1:0][W-1:0] acc;
    logic [W-1:0]        top_row;

    always_comb begin
        st_d    = st_q;
        acc     = st_q.rows;
        top_row = '0;
        if (st_q.n[st_q.bit_idx]) begin
            for (int i = 0; i < W; i++) begin
                acc[i][i] = ~acc[i][i];
            end
        end
        if (st_q.bit_idx != '0) begin
            top_row = acc[W-1];
            for (int i = W-1; i > 0; i--) begin
                acc[i] = acc[i-1];
            end
            acc[0] = '0;
            for (int i = 0; i < W; i++) begin
                if (st_q.poly[i]) acc[i] = acc[i] ^ top_row;
            end
        end
        if (start_i) begin
            st_d.active  = 1'b1;
            st_d.bit_idx = BW'(W-1);
            st_d.n       = n_i;
            st_d.poly    = poly_i;
            st_d.rows    = '0;
        end else if (st_q.active) begin
            st_d.rows = acc;
            if (st_q.bit_idx == '0) begin
                st_d.active = 1'b0;
            end else begin
                st_d.bit_idx = st_q.bit_idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign rows_o   = st_q.rows;

    assert_gen_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> st_q.active && st_q.bit_idx == BW'(W-1));
    assert_gen_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && st_q.bit_idx == '0 && !start_i |=> !st_q.active);
    assert_matrix_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active && !start_i |=> $stable(st_q.rows));

endmodule

// File: rtl/gfm_applier.sv
module gfm_applier #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0][W-1:0] rows_i,
    input  logic                in_fire_i,
    input  logic [W-1:0]        in_data_i,
    input  logic                out_ready_i,
    output logic                can_take_o,
    output logic                out_valid_o,
    output logic [W-1:0]        out_data_o
);
    import gfm_pkg::*;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } out_state_t;

    out_state_t st_q, st_d;
    logic [W-1:0] product;

    generate
        if (W == 8) begin : g_w8
            gfm_mat8_t m;
            always_comb begin
                for (int i = 0; i < 8; i++) m[i] = rows_i[i][7:0];
                product = gfm_affine8(in_data_i[7:0], m);
            end
        end else if (W == 16) begin : g_w16
            gfm_mat8_t m_ll, m_lh, m_hl, m_hh;
            always_comb begin
                for (int i = 0; i < 8; i++) begin
                    m_ll[i] = rows_i[i][7:0];
                    m_lh[i] = rows_i[i][15:8];
                    m_hl[i] = rows_i[i+8][7:0];
                    m_hh[i] = rows_i[i+8][15:8];
                end
                product[7:0]  = gfm_affine8(in_data_i[7:0], m_ll) ^ gfm_affine8(in_data_i[15:8], m_lh);
                product[15:8] = gfm_affine8(in_data_i[7:0], m_hl) ^ gfm_affine8(in_data_i[15:8], m_hh);
            end
        end else begin : g_generic
            always_comb begin
                for (int i = 0; i < W; i++) product[i] = ^(in_data_i & rows_i[i]);
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (in_fire_i) begin
            st_d.valid = 1'b1;
            st_d.data  = product;
        end else if (out_ready_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign can_take_o  = !st_q.valid || out_ready_i;
    assign out_valid_o = st_q.valid;
    assign out_data_o  = st_q.data;

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && !out_ready_i |=> st_q.valid && $stable(st_q.data));
    assert_out_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && out_ready_i && !in_fire_i |=> !st_q.valid);
    assert_fire_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire_i |=> st_q.valid);

endmodule

// File: rtl/gf_matmul_engine.sv
module gf_matmul_engine #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] const_i,
    input  logic [W-1:0] poly_i,
    output logic         busy_o,
    input  logic         in_valid_i,
    input  logic [W-1:0] in_data_i,
    output logic         in_ready_o,
    output logic         out_valid_o,
    output logic [W-1:0] out_data_o,
    input  logic         out_ready_i
);
    typedef struct packed {
        logic         pend;
        logic [W-1:0] n;
        logic [W-1:0] poly;
    } ctl_state_t;

    ctl_state_t ctl_q, ctl_d;
    logic gen_active, gen_start, can_take, in_fire;
    logic [W-1:0][W-1:0] rows;

    assign busy_o     = ctl_q.pend || gen_active;
    assign gen_start  = ctl_q.pend && !out_valid_o;
    assign in_ready_o = !busy_o && can_take;
    assign in_fire    = in_valid_i && in_ready_o;

    always_comb begin
        ctl_d = ctl_q;
        if (gen_start) begin
            ctl_d.pend = 1'b0;
        end else if (load_i && !busy_o) begin
            ctl_d.pend = 1'b1;
            ctl_d.n    = const_i;
            ctl_d.poly = poly_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    gfm_matrix_gen #(.W(W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (gen_start),
        .n_i      (ctl_q.n),
        .poly_i   (ctl_q.poly),
        .active_o (gen_active),
        .rows_o   (rows)
    );

    gfm_applier #(.W(W)) u_apply (
        .clk         (clk),
        .rst_n       (rst_n),
        .rows_i      (rows),
        .in_fire_i   (in_fire),
        .in_data_i   (in_data_i),
        .out_ready_i (out_ready_i),
        .can_take_o  (can_take),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o)
    );

    assert_gen_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gen_active |-> !out_valid_o);
    assert_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && load_i && !gen_start |=> $stable(ctl_q.n) && $stable(ctl_q.poly));
    assert_load_starts_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !busy_o |=> busy_o);

endmodule

// File: tb/tb_gf_matmul_engine.sv
`timescale 1ns/1ps
module tb_gf_matmul_engine;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] const_i = '0;
    logic [W-1:0] poly_i = '0;
    logic         busy_o;
    logic         in_valid_i = 1'b0;
    logic [W-1:0] in_data_i = '0;
    logic         in_ready_o;
    logic         out_valid_o;
    logic [W-1:0] out_data_o;
    logic         out_ready_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gf_matmul_engine #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .const_i(const_i), .poly_i(poly_i),
        .busy_o(busy_o), .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i)
    );

    // {poly, n, x}
    localparam logic [47:0] VEC [10] = '{
        {16'h002B, 16'h0002, 16'h1234},
        {16'h002B, 16'h0002, 16'hFFFF},
        {16'h002B, 16'h0003, 16'h8000},
        {16'h002B, 16'hA5C3, 16'h0001},
        {16'h002B, 16'hA5C3, 16'h8181},
        {16'h002B, 16'hA5C3, 16'h7E5A},
        {16'h100B, 16'h0100, 16'hFF00},
        {16'h100B, 16'h8001, 16'h00FF},
        {16'h100B, 16'h0000, 16'hBEEF},
        {16'h100B, 16'hFFFF, 16'hFFFF}
    };

    function automatic logic [W-1:0] gmul(input logic [W-1:0] a, input logic [W-1:0] n,
                                          input logic [W-1:0] p);
        logic [W-1:0] r = '0;
        for (int i = W-1; i >= 0; i--) begin
            r = {r[W-2:0], 1'b0} ^ (r[W-1] ? p : '0);
            if (n[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_const(input logic [W-1:0] n, input logic [W-1:0] p, output int cycles);
        load_i = 1'b1; const_i = n; poly_i = p;
        @(negedge clk);
        load_i = 1'b0;
        cycles = 0;
        while (busy_o) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic send(input logic [W-1:0] x, input logic [W-1:0] exp, input string req);
        in_valid_i = 1'b1; in_data_i = x; out_ready_i = 1'b1;
        #1;
        check({req, " in_ready"}, in_ready_o, 1);
        @(negedge clk);
        in_valid_i = 1'b0;
        check({req, " out_valid"}, out_valid_o, 1);
        check({req, " product"}, out_data_o, exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        logic [W-1:0] cur_n, cur_p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy_o, 0);
        check("R1 in_ready", in_ready_o, 1);
        check("R1 out_valid", out_valid_o, 0);
        send(16'hBEEF, 16'h0000, "R1 zero matrix");

        // R2 generation length, R3 known bit map
        load_const(16'h0002, 16'h002B, cyc);
        check("R2 busy cycles", cyc, W + 1);
        send(16'h8001, 16'h0029, "R3 bit15 fold");
        send(16'h4000, 16'h8000, "R3 shift");

        // R9 identity
        load_const(16'h0001, 16'h002B, cyc);
        send(16'hC3A5, 16'hC3A5, "R9 identity");

        // R4 table walk
        cur_n = 16'h0001; cur_p = 16'h002B;
        for (int k = 0; k < 10; k++) begin
            logic [W-1:0] p, n, x;
            {p, n, x} = VEC[k];
            if (n != cur_n || p != cur_p) begin
                load_const(n, p, cyc);
                check("R2 busy cycles table", cyc, W + 1);
                cur_n = n; cur_p = p;
            end
            send(x, gmul(x, n, p), (n == 0) ? "R9 zero const" : "R4 product");
        end

        // R6 backpressure
        load_const(16'h0007, 16'h002B, cyc);
        in_valid_i = 1'b1; in_data_i = 16'h1111; out_ready_i = 1'b0;
        @(negedge clk);
        in_data_i = 16'h2222;
        repeat (3) @(negedge clk);
        check("R6 held valid", out_valid_o, 1);
        check("R6 held data", out_data_o, gmul(16'h1111, 16'h0007, 16'h002B));
        check("R6 in_ready low", in_ready_o, 0);
        out_ready_i = 1'b1;
        #1;
        check("R6 in_ready on release", in_ready_o, 1);
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R6 next word", out_data_o, gmul(16'h2222, 16'h0007, 16'h002B));
        @(negedge clk);
        check("R5 drained", out_valid_o, 0);

        // R7 load while a word is in flight
        in_valid_i = 1'b1; in_data_i = 16'hABCD; out_ready_i = 1'b0;
        @(negedge clk);
        load_i = 1'b1; const_i = 16'h0100; poly_i = 16'h002B; in_data_i = 16'h5A5A;
        #1;
        check("R7 in_ready low", in_ready_o, 0);
        @(negedge clk);
        load_i = 1'b0;
        check("R7 busy pending", busy_o, 1);
        repeat (3) @(negedge clk);
        check("R7 busy while full", busy_o, 1);
        check("R7 old product held", out_data_o, gmul(16'hABCD, 16'h0007, 16'h002B));
        out_ready_i = 1'b1;
        @(negedge clk);
        check("R7 drained before gen", out_valid_o, 0);
        cyc = 0;
        while (busy_o) begin
            cyc++;
            @(negedge clk);
        end
        check("R7 gen cycles after drain", cyc, W + 1);
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R7 new product", out_data_o, gmul(16'h5A5A, 16'h0100, 16'h002B));
        @(negedge clk);

        // R8 load during busy ignored
        load_i = 1'b1; const_i = 16'h0005; poly_i = 16'h002B;
        @(negedge clk);
        const_i = 16'h0009;
        @(negedge clk);
        load_i = 1'b0;
        while (busy_o) @(negedge clk);
        send(16'h0F0F, gmul(16'h0F0F, 16'h0005, 16'h002B), "R8 ignored load");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule